// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block watches the divided reference pulse and the divided feedback pulse of a PLL and decides whether the loop is locked. Both pulses come from other clock domains. Each one passes through a chain of synchronizer flops into a fast sampling clock, where its rising edge is detected. For every reference edge the block measures, in sampling-clock periods, how far the nearest feedback edge lies from it, whether the feedback edge comes before or after. That reference cycle counts as good when the distance is below a fixed window. A lock flag is raised once enough good cycles have come one after another. A precision bit selects a run of three or five. Any bad cycle clears the flag at once.

The lock flag drives a status pin directly. It also gates the RF output enable: when mute-till-lock is switched on, a requested RF enable is held off until lock is reported. Power-down drives the synchronous reset, so a powered-down detector always reports unlocked and starts counting again from zero. No data flows through the block: every pin is a plain level, with no handshake and no back-pressure.

Top module: `pll_lock_monitor`

## Requirements
- R1: A reference cycle is good when a feedback rising edge lies strictly fewer than WIN_CLKS sampling clocks from the reference rising edge. The feedback edge may come before the edge, after it, or in the same sampling clock. A distance of WIN_CLKS or more makes the cycle bad.
- R2: With `precise` = 0, `lock_o` rises after three good cycles in a row. With `precise` = 1, it rises after five. It stays low before the run is complete.
- R3: A bad cycle clears the run count and drives `lock_o` low in the cycle after its verdict. The full run is then needed again.
- R4: A reference cycle counts as bad when no feedback edge arrives within WIN_CLKS sampling clocks after the reference edge.
- R5: While `rst` (power-down) is high, `lock_o` is 0. After `rst` is released, the run count starts from zero.
- R6: When `mute_en` = 0, `rf_en_o` equals `rf_req`. When `mute_en` = 1, `rf_en_o` is `rf_req` AND `lock_o`.
- R7: Once locked, `lock_o` stays high for as long as every new cycle is good, however long the run grows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, high during power-down |
| ref_pulse | input | 1 | Divided reference pulse, asynchronous |
| fb_pulse | input | 1 | Divided feedback pulse, asynchronous |
| precise | input | 1 | 1 = five-cycle run, 0 = three-cycle run |
| mute_en | input | 1 | Hold the RF enable off until lock |
| rf_req | input | 1 | Requested RF output enable |
| lock_o | output | 1 | Lock status for the status pin |
| rf_en_o | output | 1 | Gated RF output enable |

## Verification
The assertions assume the following about the inputs:
- The reference period is much longer than twice WIN_CLKS.
- Each input pulse stays high and low for at least one sampling clock.
- No second reference edge arrives while a window is still open.
- `precise` does not change between a reference edge and its verdict.

The stimulus keeps within these limits:
- It uses a 40-clock reference period with two-clock pulses.
- Feedback offsets stay within plus or minus nine clocks, and the feedback pulse is sometimes dropped.
- `precise`, `mute_en` and `rf_req` are changed only at the start of a period.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef struct packed {
    logic valid;
    logic good;
  } verdict_t;

  localparam int unsigned RUN_SHORT = 3;
  localparam int unsigned RUN_LONG  = 5;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/phase_window.sv
module phase_window
  import pll_lock_pkg::*;
#(
  parameter int unsigned WIN = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ref_rise,
  input  logic     fb_rise,
  output verdict_t verdict
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [CW-1:0] since_fb;
  logic [CW-1:0] since_ref;
  logic          open_q;
  verdict_t      v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_fb  <= CW'(WIN);
      since_ref <= '0;
      open_q    <= 1'b0;
      v_q       <= '0;
    end else begin
      v_q <= '0;
      // distance counter from the last feedback edge, saturating at WIN
      if (fb_rise)
        since_fb <= CW'(1);
      else if (since_fb < CW'(WIN))
        since_fb <= since_fb + CW'(1);

      if (ref_rise && !open_q) begin
        if (fb_rise || (since_fb < CW'(WIN))) begin
          v_q <= '{valid: 1'b1, good: 1'b1};
        end else begin
          open_q    <= 1'b1;
          since_ref <= CW'(1);
        end
      end else if (open_q) begin
        if (since_ref == CW'(WIN)) begin
          v_q    <= '{valid: 1'b1, good: 1'b0};
          open_q <= 1'b0;
        end else if (fb_rise) begin
          v_q    <= '{valid: 1'b1, good: 1'b1};
          open_q <= 1'b0;
        end else begin
          since_ref <= since_ref + CW'(1);
        end
      end
    end
  end

  assign verdict = v_q;

  assert_timeout_bad_R4: assert property (@(posedge clk) disable iff (rst)
    (open_q && since_ref == CW'(WIN)) |=> (verdict.valid && !verdict.good));

  assert_same_edge_good_R1: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise && !open_q) |=> (verdict.valid && verdict.good));
endmodule

// File: rtl/lock_run.sv
module lock_run
  import pll_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_t verdict,
  input  logic     precise,
  output logic     lock
);
  localparam int unsigned RW = $clog2(RUN_LONG + 1);

  logic [RW-1:0] run_q, run_nx, need;
  logic          lock_q, lock_nx;

  assign need = precise ? RW'(RUN_LONG) : RW'(RUN_SHORT);

  always_comb begin
    run_nx  = run_q;
    lock_nx = lock_q;
    if (verdict.valid) begin
      if (verdict.good) begin
        run_nx  = (run_q == RW'(RUN_LONG)) ? run_q : run_q + RW'(1);
        lock_nx = lock_q | (run_nx >= need);
      end else begin
        run_nx  = '0;
        lock_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      run_q  <= run_nx;
      lock_q <= lock_nx;
    end
  end

  assign lock = lock_q;

  assert_bad_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (verdict.valid && !verdict.good) |=> !lock_q);

  assert_rise_on_good_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(verdict.valid && verdict.good));

  assert_rise_count_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> ($past(run_q) >= ($past(precise) ? RW'(RUN_LONG - 1) : RW'(RUN_SHORT - 1))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !(verdict.valid && !verdict.good)) |=> lock_q);
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int unsigned WIN_CLKS    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic precise,
  input  logic mute_en,
  input  logic rf_req,
  output logic lock_o,
  output logic rf_en_o
);
  localparam int unsigned NIN = 2;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] rise_in;
  verdict_t       verdict;
  logic           lock_w;

  assign raw_in = {fb_pulse, ref_pulse};

  for (genvar g = 0; g < NIN; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .rise (rise_in[g])
    );
  end

  phase_window #(.WIN(WIN_CLKS)) u_win (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise_in[0]),
    .fb_rise  (rise_in[1]),
    .verdict  (verdict)
  );

  lock_run u_run (
    .clk     (clk),
    .rst     (rst),
    .verdict (verdict),
    .precise (precise),
    .lock    (lock_w)
  );

  assign lock_o  = lock_w;
  assign rf_en_o = rf_req & (~mute_en | lock_w);

  assert_mute_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (mute_en && !lock_o) |-> !rf_en_o);
endmodule

// File: tb/pll_lock_monitor_test.sv
`timescale 1ns/1ps
module pll_lock_monitor_test;
  localparam int WIN = 3;
  localparam int PER = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_pulse = 1'b0, fb_pulse = 1'b0, precise = 1'b0;
  logic mute_en = 1'b0, rf_req = 1'b0;
  logic lock_o, rf_en_o;

  int checks = 0, fails = 0;
  int m_run = 0;
  bit m_lock = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_lock_monitor #(.WIN_CLKS(WIN), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .precise(precise), .mute_en(mute_en), .rf_req(rf_req),
    .lock_o(lock_o), .rf_en_o(rf_en_o)
  );

  function automatic bit cycle_good(int off, bit present);
    return present && (off > -WIN) && (off < WIN);
  endfunction

  function automatic bit rf_expect(bit req, bit men, bit lk);
    return req && (!men || lk);
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic model_step(int off, bit present, bit prec);
    int need;
    need = prec ? 5 : 3;
    if (cycle_good(off, present)) begin
      if (m_run < 5) m_run++;
      m_lock = m_lock || (m_run >= need);
    end else begin
      m_run  = 0;
      m_lock = 1'b0;
    end
  endtask

  task automatic ref_cycle(int off, bit present, bit prec, bit req, bit men, string tag);
    model_step(off, present, prec);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (i == 30) begin
        check(lock_o, m_lock, tag);
        check(rf_en_o, rf_expect(req, men, m_lock), "R6");
      end
      precise   = prec;
      rf_req    = req;
      mute_en   = men;
      ref_pulse = (i == 10) || (i == 11);
      fb_pulse  = present && ((i == 10 + off) || (i == 11 + off));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    m_run = 0;
    m_lock = 1'b0;
    ref_pulse = 1'b0;
    fb_pulse = 1'b0;
    repeat (3) @(negedge clk);
    mute_en = 1'b1; rf_req = 1'b1;
    @(negedge clk);
    check(lock_o, 1'b0, "R5");
    check(rf_en_o, 1'b0, "R6");
    mute_en = 1'b0;
    @(negedge clk);
    check(rf_en_o, 1'b1, "R6");
    rst = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    do_reset();
    // R2: short run of three with mixed early, late and coincident edges
    ref_cycle(0, 1, 0, 1, 1, "R1");
    ref_cycle(WIN - 1, 1, 0, 1, 1, "R2");
    ref_cycle(-(WIN - 1), 1, 0, 1, 1, "R2");
    ref_cycle(1, 1, 0, 1, 1, "R7");
    // R1 boundary: exactly WIN late is bad
    ref_cycle(WIN, 1, 0, 1, 1, "R3");
    ref_cycle(0, 1, 0, 1, 1, "R3");
    ref_cycle(0, 1, 0, 1, 1, "R3");
    ref_cycle(-1, 1, 0, 1, 1, "R2");
    // R1 boundary: exactly WIN early is bad
    ref_cycle(-WIN, 1, 0, 1, 0, "R1");
    // R4: missing feedback
    ref_cycle(0, 1, 0, 1, 1, "R4");
    ref_cycle(0, 1, 0, 1, 1, "R4");
    ref_cycle(0, 0, 0, 1, 1, "R4");
    // R2: long run of five
    for (int k = 0; k < 6; k++) ref_cycle(k % 2, 1, 1, 1, 1, "R2");
    ref_cycle(9, 1, 1, 1, 1, "R3");
    // R5: power-down mid-lock, then restart from zero
    for (int k = 0; k < 3; k++) ref_cycle(0, 1, 0, 1, 1, "R2");
    do_reset();
    ref_cycle(0, 1, 0, 1, 1, "R5");
    ref_cycle(0, 1, 0, 1, 1, "R5");
    ref_cycle(0, 1, 0, 1, 1, "R5");
    // R7: long lock hold
    for (int k = 0; k < 10; k++) ref_cycle(0, 1, 0, 1, 1, "R7");
    // random mix
    for (int k = 0; k < 200; k++) begin
      int off;
      bit pres, prec, req, men;
      off  = int'($urandom_range(10)) - 5;
      pres = ($urandom_range(19) != 0);
      prec = 1'($urandom_range(1));
      req  = 1'($urandom_range(1));
      men  = 1'($urandom_range(1));
      if ($urandom_range(3) != 0 && (off >= WIN || off <= -WIN)) off = off / 2;
      ref_cycle(off, pres, prec, req, men, "R1/R2/R3");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule